// File: doc/BRIEF.md
# SATA Lane Override Reset Sequencer

This block brings a single SATA port's link up through a shared SerDes lane. A one-cycle `start` pulse launches a run. Each attempt follows the same steps:

1. The sequencer releases the receive override on the port's lane.
2. It asks an external link-reset unit for a hard reset.
3. It waits while the lane still reports half-rate operation.
4. It re-applies the receive override. This step forces the DPLL mode, pulses the DPLL reset and then holds a settle interval.
5. When the attenuation value asks for it, the sequencer also forces the transmit attenuation.

Each attempt ends with a decision based on the link-reset unit's verdict. The block either tries again or finishes with a `done` pulse and the final `online` state.

All lane register traffic goes to a SerDes register access engine through a request/acknowledge port. Each request is a read or a 16-bit write to an address. The upper byte of the address selects the lane page (0x20 plus the lane number). The lower byte selects one of four registers. The settle interval is counted in ticks of a prescaler, so both the interval and the tick period are parameters. A test setup can shrink them.

Top module: `sata_lane_reset_seq`

## Requirements
- R1: While reset is held and after it is released, `done`, `online`, `reg_req` and `hr_req` are low.
- R2: Every register access uses address `{8'h20 + lane, offset}`. The offsets are 0x01 (transmit status), 0x02 (receive status), 0x04 (transmit override) and 0x05 (receive override). The lane is the value latched at start.
- R3: Each attempt opens with a read of receive status. The value read is written to receive override with bit 14 cleared, and only then is `hr_req` raised.
- R4: After `hr_done`, receive status is read again while its bit 0 reads 1. The number of these reads is at most POLL_LIMIT.
- R5: A fresh read of receive status gives a value T. Five writes to receive override follow, in this order:
  1. T with bit 14 cleared.
  2. T with bit 14 set.
  3. The previous word with bits 10:8 replaced by 3.
  4. That word with bit 11 set.
  5. That word with bit 11 cleared.
- R6: After the fifth receive override write, no register request is issued for at least SETTLE_TICKS × TICK_CYCLES cycles.
- R7: When bit 3 of the latched attenuation is 0, a read of transmit status gives a value U. Three writes to transmit override follow:
  1. U with bit 15 cleared.
  2. U with bit 15 set.
  3. U with bit 15 set and bits 12:10 ORed with attenuation bits 2:0.

  When bit 3 is 1, no transmit access occurs.
- R8: While the link is not online, the attempt repeats. There are at most MAX_RETRY repeats after the first attempt, so at most MAX_RETRY+1 hard resets per run.
- R9: The run ends after the current attempt when `hr_stat_ok` is 0 or `hr_det` is 0 at `hr_done`.
- R10: Each run ends with `done` high for exactly one cycle. In that cycle `online` equals `hr_online` from the last hard reset. `online` then holds until the next accepted start.
- R11: A `start` pulse that arrives while a run is in progress has no effect.
- R12: `reg_req` stays high with stable address, direction and data until `reg_ack`. `hr_req` stays high until `hr_done`. The two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a run when idle |
| lane | input | LANE_W | Lane number of the port, latched at start |
| tx_atten | input | 4 | Transmit attenuation; bit 3 set skips the transmit override |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Write data |
| reg_ack | input | 1 | One-cycle completion of the current access |
| reg_rdata | input | DATA_W | Read data, valid with `reg_ack` |
| hr_req | output | 1 | Hard-reset request to the link-reset unit |
| hr_done | input | 1 | One-cycle completion of the hard reset |
| hr_online | input | 1 | Link came up during the hard reset |
| hr_stat_ok | input | 1 | Status read after the hard reset succeeded |
| hr_det | input | 2 | Device detection field from the link status |
| online | output | 1 | Result of the last completed run |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong state or step index shows at the register port on the very next request. The address offset, the direction or the word written differs from the expected transaction list entry. A corrupted snapshot appears in the first override write after the read that loaded it. A miscounted retry or poll budget changes the number of hard resets or status reads seen before `done`. A shortened settle interval shows as a smaller gap between the last receive override write and the next request.

// File: rtl/lrs_pkg.sv
// Shared constants and types of the lane override reset sequencer.
// Assumes a 16-bit or wider register data path and an 8-bit register
// offset inside each lane page.
package lrs_pkg;

    // Register offsets inside a lane page
    localparam logic [7:0] OFS_TX_STAT = 8'h01;
    localparam logic [7:0] OFS_RX_STAT = 8'h02;
    localparam logic [7:0] OFS_TX_OVR  = 8'h04;
    localparam logic [7:0] OFS_RX_OVR  = 8'h05;
    // Page number of lane 0; lane n lives at page PAGE_BASE + n
    localparam logic [7:0] PAGE_BASE   = 8'h20;

    // Bit positions inside the lane registers
    localparam int BIT_HALF_RATE  = 0;
    localparam int BIT_DPLL_RST   = 11;
    localparam int BIT_RX_OVR_EN  = 14;
    localparam int BIT_TX_OVR_EN  = 15;
    localparam int DPLL_LSB       = 8;
    localparam int ATTEN_LSB      = 10;
    localparam int BIT_ATTEN_SKIP = 3;
    localparam logic [2:0] DPLL_FORCED_MODE = 3'd3;

    // Last step index of each write burst
    localparam logic [2:0] RX_LAST_STEP = 3'd4;
    localparam logic [2:0] TX_LAST_STEP = 3'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DIS_RD,
        ST_DIS_WR,
        ST_HRST,
        ST_POLL,
        ST_RX_RD,
        ST_RX_WR,
        ST_SETTLE,
        ST_TX_RD,
        ST_TX_WR,
        ST_DECIDE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       ok;
        logic       online;
        logic [1:0] det;
    } hr_result_t;

endpackage

// File: rtl/lrs_budget.sv
// Down-counting budget: loads LIMIT, counts down on dec, stops at zero.
// Used for both the retry budget and the half-rate poll budget.
module lrs_budget #(
    parameter int LIMIT = 100,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    output logic [CW-1:0] left
);

    // Holds the remaining budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (load) begin
            left <= CW'(LIMIT);
        end else if (dec && (left != '0)) begin
            left <= left - CW'(1);
        end
    end

endmodule

// File: rtl/lrs_settle_timer.sv
// Settle interval timer: a prescaler of TICK_CYCLES clock cycles drives a
// tick counter that stops at SETTLE_TICKS. Load restarts the interval;
// expired stays high until the next load.
module lrs_settle_timer #(
    parameter int TICK_CYCLES  = 250000,
    parameter int SETTLE_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int TW = $clog2(SETTLE_TICKS + 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] ticks_q;

    // Advances the prescaler and the tick count until the interval ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (load) begin
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (ticks_q != TW'(SETTLE_TICKS)) begin
            if (pre_q == PW'(TICK_CYCLES - 1)) begin
                pre_q   <= '0;
                ticks_q <= ticks_q + TW'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

    // Interval over once all ticks are counted
    always_comb expired = (ticks_q == TW'(SETTLE_TICKS));

endmodule

// File: rtl/lrs_bus_map.sv
// Decodes the sequencer state into the register access request and the
// hard-reset request, and builds each override word from the last
// snapshot read. Purely combinational; every word depends only on the
// snapshot, the step index and the latched attenuation.
module lrs_bus_map
    import lrs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANE_W = 2
) (
    input  seq_state_e        state,
    input  logic [2:0]        step,
    input  logic [DATA_W-1:0] snap,
    input  logic [3:0]        atten,
    input  logic [LANE_W-1:0] lane,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              hr_req
);

    logic [7:0]        ofs;
    logic [7:0]        page;
    logic [DATA_W-1:0] rx_en;
    logic [DATA_W-1:0] rx_mode;
    logic [DATA_W-1:0] tx_en;
    logic [DATA_W-1:0] tx_full;

    // Request, direction and register offset for each state
    always_comb begin
        reg_req = 1'b0;
        reg_wr  = 1'b0;
        ofs     = OFS_RX_STAT;
        hr_req  = 1'b0;
        unique case (state)
            ST_DIS_RD: begin reg_req = 1'b1; ofs = OFS_RX_STAT; end
            ST_DIS_WR: begin reg_req = 1'b1; reg_wr = 1'b1; ofs = OFS_RX_OVR; end
            ST_HRST:   hr_req = 1'b1;
            ST_POLL:   begin reg_req = 1'b1; ofs = OFS_RX_STAT; end
            ST_RX_RD:  begin reg_req = 1'b1; ofs = OFS_RX_STAT; end
            ST_RX_WR:  begin reg_req = 1'b1; reg_wr = 1'b1; ofs = OFS_RX_OVR; end
            ST_TX_RD:  begin reg_req = 1'b1; ofs = OFS_TX_STAT; end
            ST_TX_WR:  begin reg_req = 1'b1; reg_wr = 1'b1; ofs = OFS_TX_OVR; end
            default:   ;
        endcase
    end

    // Lane page selects the upper address byte
    always_comb begin
        page     = PAGE_BASE + 8'(lane);
        reg_addr = {(ADDR_W - 8)'(page), ofs};
    end

    // Intermediate override words derived from the snapshot
    always_comb begin
        rx_en                        = snap;
        rx_en[BIT_RX_OVR_EN]         = 1'b1;
        rx_mode                      = rx_en;
        rx_mode[DPLL_LSB +: 3]       = DPLL_FORCED_MODE;
        tx_en                        = snap;
        tx_en[BIT_TX_OVR_EN]         = 1'b1;
        tx_full                      = tx_en;
        tx_full[ATTEN_LSB +: 3]      = tx_en[ATTEN_LSB +: 3] | atten[2:0];
    end

    // Selects the word written in the current state and step
    always_comb begin
        reg_wdata = '0;
        if (state == ST_DIS_WR) begin
            reg_wdata                = snap;
            reg_wdata[BIT_RX_OVR_EN] = 1'b0;
        end else if (state == ST_RX_WR) begin
            unique case (step)
                3'd0: begin
                    reg_wdata                = snap;
                    reg_wdata[BIT_RX_OVR_EN] = 1'b0;
                end
                3'd1: reg_wdata = rx_en;
                3'd2: reg_wdata = rx_mode;
                3'd3: begin
                    reg_wdata               = rx_mode;
                    reg_wdata[BIT_DPLL_RST] = 1'b1;
                end
                default: begin
                    reg_wdata               = rx_mode;
                    reg_wdata[BIT_DPLL_RST] = 1'b0;
                end
            endcase
        end else if (state == ST_TX_WR) begin
            unique case (step)
                3'd0: begin
                    reg_wdata                = snap;
                    reg_wdata[BIT_TX_OVR_EN] = 1'b0;
                end
                3'd1:    reg_wdata = tx_en;
                default: reg_wdata = tx_full;
            endcase
        end
    end

endmodule

// File: rtl/lrs_ctrl.sv
// Main state machine of the lane override reset sequencer. Walks one
// attempt (release, hard reset, half-rate poll, receive override, settle,
// optional transmit override) and decides whether to retry. Assumes the
// register engine acknowledges each access with a one-cycle reg_ack and
// the link-reset unit ends each reset with a one-cycle hr_done.
module lrs_ctrl
    import lrs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LANE_W-1:0] lane,
    input  logic [3:0]        tx_atten,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              hr_done,
    input  hr_result_t        hr_res,
    input  logic              timer_expired,
    input  logic              retry_empty,
    input  logic              poll_last,
    output seq_state_e        state,
    output logic [2:0]        step,
    output logic [DATA_W-1:0] snap,
    output logic [LANE_W-1:0] lane_q,
    output logic [3:0]        atten_q,
    output logic              timer_load,
    output logic              retry_load,
    output logic              retry_dec,
    output logic              poll_load,
    output logic              poll_dec,
    output logic              busy,
    output logic              done,
    output logic              online
);

    hr_result_t res_q;
    logic       finish;

    // Run ends on a failed status read, no device, link up or no budget
    always_comb begin
        finish = !res_q.ok || (res_q.det == 2'b00) || res_q.online || retry_empty;
    end

    // Sequencing of one run through its attempts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            step    <= '0;
            snap    <= '0;
            lane_q  <= '0;
            atten_q <= '0;
            res_q   <= '0;
            online  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        lane_q  <= lane;
                        atten_q <= tx_atten;
                        online  <= 1'b0;
                        state   <= ST_DIS_RD;
                    end
                end
                ST_DIS_RD: begin
                    if (reg_ack) begin
                        snap  <= reg_rdata;
                        state <= ST_DIS_WR;
                    end
                end
                ST_DIS_WR: begin
                    if (reg_ack) state <= ST_HRST;
                end
                ST_HRST: begin
                    if (hr_done) begin
                        res_q <= hr_res;
                        state <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (reg_ack && !(reg_rdata[BIT_HALF_RATE] && !poll_last)) begin
                        state <= ST_RX_RD;
                    end
                end
                ST_RX_RD: begin
                    if (reg_ack) begin
                        snap  <= reg_rdata;
                        step  <= '0;
                        state <= ST_RX_WR;
                    end
                end
                ST_RX_WR: begin
                    if (reg_ack) begin
                        if (step == RX_LAST_STEP) begin
                            step  <= '0;
                            state <= ST_SETTLE;
                        end else begin
                            step <= step + 3'd1;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (timer_expired) begin
                        state <= atten_q[BIT_ATTEN_SKIP] ? ST_DECIDE : ST_TX_RD;
                    end
                end
                ST_TX_RD: begin
                    if (reg_ack) begin
                        snap  <= reg_rdata;
                        step  <= '0;
                        state <= ST_TX_WR;
                    end
                end
                ST_TX_WR: begin
                    if (reg_ack) begin
                        if (step == TX_LAST_STEP) begin
                            step  <= '0;
                            state <= ST_DECIDE;
                        end else begin
                            step <= step + 3'd1;
                        end
                    end
                end
                ST_DECIDE: begin
                    if (finish) begin
                        online <= res_q.online;
                        state  <= ST_DONE;
                    end else begin
                        state <= ST_DIS_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobes to the budgets and the settle timer
    always_comb begin
        retry_load = (state == ST_IDLE) && start;
        retry_dec  = (state == ST_DECIDE) && !finish;
        poll_load  = (state == ST_HRST) && hr_done;
        poll_dec   = (state == ST_POLL) && reg_ack;
        timer_load = (state == ST_RX_WR) && reg_ack && (step == RX_LAST_STEP);
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
    end

endmodule

// File: rtl/sata_lane_reset_seq.sv
// Top of the lane override reset sequencer. Wraps each hard reset of one
// SATA port with the release and re-application of the lane overrides
// and retries under a bounded budget. Assumes one port per instance and
// a register engine that serialises accesses from several instances.
module sata_lane_reset_seq
    import lrs_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int LANE_W       = 2,
    parameter int MAX_RETRY    = 100,
    parameter int POLL_LIMIT   = 1000,
    parameter int TICK_CYCLES  = 250000,
    parameter int SETTLE_TICKS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LANE_W-1:0] lane,
    input  logic [3:0]        tx_atten,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              hr_req,
    input  logic              hr_done,
    input  logic              hr_online,
    input  logic              hr_stat_ok,
    input  logic [1:0]        hr_det,
    output logic              online,
    output logic              done
);

    localparam int RCW = $clog2(MAX_RETRY + 1);
    localparam int PCW = $clog2(POLL_LIMIT + 1);

    seq_state_e        state;
    logic [2:0]        step;
    logic [DATA_W-1:0] snap;
    logic [LANE_W-1:0] lane_q;
    logic [3:0]        atten_q;
    logic              timer_load, timer_expired;
    logic              retry_load, retry_dec, poll_load, poll_dec;
    logic              busy;
    logic [RCW-1:0]    retry_left;
    logic [PCW-1:0]    poll_left;
    hr_result_t        hr_res;

    // Packs the link-reset verdict for the controller
    always_comb hr_res = '{ok: hr_stat_ok, online: hr_online, det: hr_det};

    lrs_ctrl #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .lane          (lane),
        .tx_atten      (tx_atten),
        .reg_ack       (reg_ack),
        .reg_rdata     (reg_rdata),
        .hr_done       (hr_done),
        .hr_res        (hr_res),
        .timer_expired (timer_expired),
        .retry_empty   (retry_left == '0),
        .poll_last     (poll_left == PCW'(1)),
        .state         (state),
        .step          (step),
        .snap          (snap),
        .lane_q        (lane_q),
        .atten_q       (atten_q),
        .timer_load    (timer_load),
        .retry_load    (retry_load),
        .retry_dec     (retry_dec),
        .poll_load     (poll_load),
        .poll_dec      (poll_dec),
        .busy          (busy),
        .done          (done),
        .online        (online)
    );

    lrs_bus_map #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) map_i (
        .state     (state),
        .step      (step),
        .snap      (snap),
        .atten     (atten_q),
        .lane      (lane_q),
        .reg_req   (reg_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hr_req    (hr_req)
    );

    lrs_settle_timer #(
        .TICK_CYCLES  (TICK_CYCLES),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .expired (timer_expired)
    );

    lrs_budget #(
        .LIMIT (MAX_RETRY),
        .CW    (RCW)
    ) retry_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (retry_load),
        .dec   (retry_dec),
        .left  (retry_left)
    );

    lrs_budget #(
        .LIMIT (POLL_LIMIT),
        .CW    (PCW)
    ) poll_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (poll_load),
        .dec   (poll_dec),
        .left  (poll_left)
    );

endmodule

// File: rtl/sata_lane_reset_seq_chk.sv
// Protocol and budget checks of the lane override reset sequencer,
// bound to the top module. Latches the lane and attenuation at each
// accepted start and counts hard resets per run.
module sata_lane_reset_seq_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int LANE_W    = 2,
    parameter int MAX_RETRY = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LANE_W-1:0] lane,
    input logic [3:0]        tx_atten,
    input logic              busy,
    input logic              reg_req,
    input logic              reg_wr,
    input logic              reg_ack,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              hr_req,
    input logic              hr_done,
    input logic              online,
    input logic              done
);

    logic [LANE_W-1:0] lane_l;
    logic [3:0]        atten_l;
    logic              hr_q;
    int unsigned       hr_count;

    // Tracks run parameters and the hard resets issued in this run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_l   <= '0;
            atten_l  <= '0;
            hr_q     <= 1'b0;
            hr_count <= 0;
        end else begin
            hr_q <= hr_req;
            if (start && !busy) begin
                lane_l   <= lane;
                atten_l  <= tx_atten;
                hr_count <= 0;
            end else if (hr_req && !hr_q) begin
                hr_count <= hr_count + 1;
            end
        end
    end

    // R12: access held stable until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_wr) && $stable(reg_wdata));

    // R12: hard-reset request held until completion
    p_hr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hr_req && !hr_done |=> hr_req);

    // R12: never both requests at once
    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && hr_req));

    // R2: every access goes to the latched lane page
    p_lane_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> (reg_addr[ADDR_W-1:8] == (ADDR_W - 8)'(8'h20 + 8'(lane_l))));

    // R7: no transmit register access when the skip bit is set
    p_tx_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && atten_l[3] |-> (reg_addr[7:0] != 8'h01) && (reg_addr[7:0] != 8'h04));

    // R8: hard resets per run stay within the budget
    p_retry_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hr_count <= MAX_RETRY + 1);

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10, R11: result holds while idle without start
    p_online_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(online));

    // R11: idle issues no requests
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !reg_req && !hr_req);

endmodule

bind sata_lane_reset_seq sata_lane_reset_seq_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LANE_W    (LANE_W),
    .MAX_RETRY (MAX_RETRY)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lane      (lane),
    .tx_atten  (tx_atten),
    .busy      (busy),
    .reg_req   (reg_req),
    .reg_wr    (reg_wr),
    .reg_ack   (reg_ack),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .hr_req    (hr_req),
    .hr_done   (hr_done),
    .online    (online),
    .done      (done)
);

// File: tb/sata_lane_reset_seq_tb_top.sv
`timescale 1ns/1ps
module sata_lane_reset_seq_tb_top;

    localparam int MAX_RETRY    = 5;
    localparam int POLL_LIMIT   = 8;
    localparam int TICK_CYCLES  = 4;
    localparam int SETTLE_TICKS = 15;
    localparam int SETTLE_CYC   = TICK_CYCLES * SETTLE_TICKS;
    localparam int LOG_N        = 512;

    typedef struct packed {
        logic [1:0]  lane;
        logic [3:0]  atten;
        logic [15:0] rx_base;
        logic [15:0] tx_base;
        logic [7:0]  half;
        logic [7:0]  fails;
        logic [7:0]  det0;
        logic [7:0]  err;
        logic [7:0]  exp_att;
        logic        exp_onl;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'h5, 16'h4A20, 16'h9003, 8'd0,  8'd0,   8'd255, 8'd255, 8'd1, 1'b1},
        '{2'd2, 4'h9, 16'h0F00, 16'h1234, 8'd3,  8'd2,   8'd255, 8'd255, 8'd3, 1'b1},
        '{2'd3, 4'h7, 16'h0800, 16'h8000, 8'd20, 8'd255, 8'd2,   8'd255, 8'd2, 1'b0},
        '{2'd1, 4'h0, 16'h0000, 16'h0400, 8'd0,  8'd255, 8'd255, 8'd1,   8'd1, 1'b0},
        '{2'd1, 4'h3, 16'h1100, 16'h0002, 8'd1,  8'd255, 8'd255, 8'd255, 8'd6, 1'b0},
        '{2'd2, 4'h2, 16'h0200, 16'h6000, 8'd2,  8'd5,   8'd255, 8'd255, 8'd6, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  lane = '0;
    logic [3:0]  tx_atten = '0;
    logic        reg_req, reg_wr;
    logic [15:0] reg_addr, reg_wdata;
    logic        reg_ack = 1'b0;
    logic [15:0] reg_rdata = '0;
    logic        hr_req;
    logic        hr_done = 1'b0;
    logic        hr_online = 1'b0;
    logic        hr_stat_ok = 1'b0;
    logic [1:0]  hr_det = '0;
    logic        online, done;

    sata_lane_reset_seq #(
        .MAX_RETRY    (MAX_RETRY),
        .POLL_LIMIT   (POLL_LIMIT),
        .TICK_CYCLES  (TICK_CYCLES),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .lane (lane), .tx_atten (tx_atten),
        .reg_req (reg_req), .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_ack (reg_ack), .reg_rdata (reg_rdata), .hr_req (hr_req), .hr_done (hr_done),
        .hr_online (hr_online), .hr_stat_ok (hr_stat_ok), .hr_det (hr_det),
        .online (online), .done (done)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Device model configuration
    vec_t cfg;
    int   hl_m = 0;
    int   hr_k = 0;
    int   hr_wait = 0;
    int   done_cnt = 0;
    logic onl_seen = 1'b0;

    // Transaction log
    logic        log_wr   [LOG_N];
    logic [15:0] log_addr [LOG_N];
    logic [15:0] log_data [LOG_N];
    int          log_t    [LOG_N];
    int          log_n = 0;

    // Expected list
    logic        exp_wr   [LOG_N];
    logic [15:0] exp_addr [LOG_N];
    logic [15:0] exp_data [LOG_N];
    int          exp_n = 0;
    int          hl_b = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Register engine, link-reset unit and done monitor, away from the edge
    always @(negedge clk) begin
        if (reg_ack) begin
            reg_ack = 1'b0;
        end else if (reg_req && rst_n) begin
            reg_rdata = 16'h0000;
            if (!reg_wr && reg_addr[7:0] == 8'h02) begin
                reg_rdata = cfg.rx_base | ((hl_m > 0) ? 16'h0001 : 16'h0000);
                if (hl_m > 0) hl_m = hl_m - 1;
            end else if (!reg_wr && reg_addr[7:0] == 8'h01) begin
                reg_rdata = cfg.tx_base;
            end
            if (log_n < LOG_N) begin
                log_wr[log_n]   = reg_wr;
                log_addr[log_n] = reg_addr;
                log_data[log_n] = reg_wr ? reg_wdata : 16'h0000;
                log_t[log_n]    = cyc;
            end
            log_n = log_n + 1;
            reg_ack = 1'b1;
        end
        if (hr_done) begin
            hr_done = 1'b0;
        end else if (hr_req && rst_n) begin
            if (hr_wait == 3) begin
                hr_wait    = 0;
                hr_k       = hr_k + 1;
                hr_online  = (hr_k > int'(cfg.fails));
                hr_stat_ok = (hr_k != int'(cfg.err));
                hr_det     = (hr_k == int'(cfg.det0)) ? 2'd0 : 2'd3;
                hl_m       = int'(cfg.half);
                hr_done    = 1'b1;
            end else begin
                hr_wait = hr_wait + 1;
            end
        end
        if (done) begin
            done_cnt = done_cnt + 1;
            onl_seen = online;
        end
    end

    task automatic chk(input logic ok, input string what, input int act, input int expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic push(input logic w, input logic [15:0] a, input logic [15:0] d);
        if (exp_n < LOG_N) begin
            exp_wr[exp_n] = w; exp_addr[exp_n] = a; exp_data[exp_n] = d;
        end
        exp_n = exp_n + 1;
    endtask

    task automatic rx_read(input vec_t v, output logic [15:0] val);
        val = v.rx_base | ((hl_b > 0) ? 16'h0001 : 16'h0000);
        if (hl_b > 0) hl_b = hl_b - 1;
        push(1'b0, {8'h20 + 8'(v.lane), 8'h02}, 16'h0000);
    endtask

    // Builds the expected transaction list of one run from the requirements
    task automatic build_expected(input vec_t v);
        logic [15:0] val, t, m, u;
        logic [7:0]  pg;
        int k = 0, n;
        logic fin = 1'b0, ok, onl;
        logic [1:0] det;
        exp_n = 0; hl_b = 0;
        pg = 8'h20 + 8'(v.lane);
        while (!fin) begin
            k = k + 1;
            rx_read(v, val);                                   // R3
            push(1'b1, {pg, 8'h05}, val & ~16'h4000);
            hl_b = int'(v.half);
            ok = (k != int'(v.err)); onl = (k > int'(v.fails));
            det = (k == int'(v.det0)) ? 2'd0 : 2'd3;
            n = 0;                                             // R4
            do begin
                rx_read(v, val);
                n = n + 1;
            end while (val[0] && n < POLL_LIMIT);
            rx_read(v, t);                                     // R5
            m = t | 16'h4000;
            push(1'b1, {pg, 8'h05}, t & ~16'h4000);
            push(1'b1, {pg, 8'h05}, m);
            m = (m & ~16'h0700) | 16'h0300;
            push(1'b1, {pg, 8'h05}, m);
            push(1'b1, {pg, 8'h05}, m | 16'h0800);
            push(1'b1, {pg, 8'h05}, m & ~16'h0800);
            if (!v.atten[3]) begin                             // R7
                push(1'b0, {pg, 8'h01}, 16'h0000);
                u = v.tx_base;
                push(1'b1, {pg, 8'h04}, u & ~16'h8000);
                push(1'b1, {pg, 8'h04}, u | 16'h8000);
                push(1'b1, {pg, 8'h04}, (u | 16'h8000) | ((16'(v.atten) << 10) & 16'h1C00));
            end
            fin = !ok || (det == 2'd0) || onl || (k == MAX_RETRY + 1);
        end
    endtask

    task automatic launch(input vec_t v);
        cfg = v; hl_m = 0; hr_k = 0; hr_wait = 0; log_n = 0;
        @(negedge clk);
        lane = v.lane; tx_atten = v.atten; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lane = ~v.lane; tx_atten = ~v.atten;
    endtask

    task automatic wait_done(input int base);
        for (int w = 0; w < 20000 && done_cnt == base; w++) @(negedge clk);
    endtask

    task automatic compare_log(input string tag);
        int mism = 0, first = -1;
        for (int i = 0; i < exp_n && i < log_n && i < LOG_N; i++) begin
            if (log_wr[i] !== exp_wr[i] || log_addr[i] !== exp_addr[i] || log_data[i] !== exp_data[i]) begin
                mism = mism + 1;
                if (first < 0) first = i;
            end
        end
        chk(log_n == exp_n, {tag, " R4 transaction count"}, log_n, exp_n);
        if (first >= 0)
            chk(1'b0, $sformatf("%s R2 R3 R5 R7 entry %0d addr/data", tag, first),
                int'({log_addr[first], log_data[first]}), int'({exp_addr[first], exp_data[first]}));
        else
            chk(1'b1, "", 0, 0);
    endtask

    initial begin
        int base;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        chk(online == 1'b0, "R1 online in reset", int'(online), 0);
        chk(reg_req == 1'b0 && hr_req == 1'b0, "R1 requests in reset", int'({reg_req, hr_req}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !online && !reg_req && !hr_req, "R1 state after reset",
            int'({done, online, reg_req, hr_req}), 0);

        // Vector table: R2 R3 R4 R5 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            build_expected(VECS[i]);
            base = done_cnt;
            launch(VECS[i]);
            wait_done(base);
            repeat (6) @(negedge clk);
            compare_log($sformatf("vec%0d", i));
            chk(hr_k == int'(VECS[i].exp_att), $sformatf("vec%0d R8 R9 hard resets", i), hr_k, int'(VECS[i].exp_att));
            chk(onl_seen == VECS[i].exp_onl, $sformatf("vec%0d R10 online at done", i), int'(onl_seen), int'(VECS[i].exp_onl));
            chk(done_cnt == base + 1, $sformatf("vec%0d R10 done pulses", i), done_cnt - base, 1);
            chk(online == VECS[i].exp_onl, $sformatf("vec%0d R10 online held", i), int'(online), int'(VECS[i].exp_onl));
            if (i == 0) begin
                // R6: gap after the fifth receive override write (entry 8) to the transmit read
                chk(log_t[9] - log_t[8] >= SETTLE_CYC, "R6 settle gap", log_t[9] - log_t[8], SETTLE_CYC);
            end
        end

        // R11: a second start during a run is ignored
        build_expected(VECS[0]);
        base = done_cnt;
        launch(VECS[0]);
        repeat (10) @(negedge clk);
        lane = 2'd3; tx_atten = 4'h8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(base);
        repeat (150) @(negedge clk);
        chk(done_cnt == base + 1, "R11 done pulses with extra start", done_cnt - base, 1);
        chk(hr_k == 1, "R11 hard resets with extra start", hr_k, 1);
        compare_log("busy-start R11");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule